// File: doc/BRIEF.md
# Red-Black Grid Relaxation Array

This block solves Laplace's equation on a small square grid of unsigned fixed-point values. All values sit in local registers. A ring of fixed edge values surrounds an interior of NI by NI cells. Each interior cell belongs to one of two checkerboard classes, chosen by the parity of its row plus column. In one half-step, every cell of one class is replaced by the average of its four orthogonal neighbours. Because no cell has a neighbour of its own class, a whole class can be rewritten in a single clock. One full sweep therefore takes exactly two cycles, whatever the grid size.

Before a run, a host loads edge values and starting interior values through a write port while the block is idle. A start pulse then launches a run of a requested number of sweeps. A completion pulse marks the end of the run. Any cell can be read at any time through a combinational row/column read port.

An optional convergence mode tracks the largest absolute change of any cell over a sweep. It ends the run early once that change drops to or below a programmed threshold.

Top module: `rb_relax_top`

## Requirements
- R1: After reset every grid cell reads 0, and both `done` and `busy` are low.
- R2: While `busy` is low, a write with `wr_en` high stores `wr_data` at full-grid position (`wr_row`, `wr_col`). Row 0 is the north edge, row NI+1 the south edge, column 0 the west edge and column NI+1 the east edge. The value reads back combinationally on `rd_data` from the next cycle on. Positions outside the grid read as 0.
- R3: In the first cycle of each sweep, every interior cell with (row + column) even takes the average of its north, south, east and west neighbours. Cells with odd parity hold their value in that cycle.
- R4: In the second cycle of each sweep, every interior cell with (row + column) odd takes the average of its four neighbours, using the values produced in the first cycle. Even cells hold their value in that cycle.
- R5: The average is the 18-bit sum of the four 16-bit neighbours, shifted right by two and truncated. It never wraps: four neighbours of 0xFFFF give 0xFFFF.
- R6: Edge cells (row 0, row NI+1, column 0, column NI+1) never change during a run.
- R7: `start` while idle with a non-zero `iter_count` of k raises `busy` in the next cycle and runs k sweeps. `done` is high for one cycle, 2k cycles after the edge that sampled `start`, and `busy` falls in that same cycle.
- R8: `start` with `iter_count` of 0 raises `done` on the next edge, leaves `busy` low and changes no cell.
- R9: While `busy` is high, writes and further `start` pulses are ignored. The grid contents and the run length are unaffected.
- R10: With `conv_en` high at start, the run ends after the first sweep whose largest absolute cell change is at or below `conv_thresh`. If no sweep meets the threshold, the run ends after `iter_count` sweeps.
- R11: With `conv_en` low at start, the run always lasts `iter_count` sweeps, even when no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe for one grid cell |
| wr_row | input | AW | Full-grid row of the load |
| wr_col | input | AW | Full-grid column of the load |
| wr_data | input | DW | Value to load |
| start | input | 1 | Launches a run when idle |
| iter_count | input | CW | Number of sweeps to run |
| conv_en | input | 1 | Enables early stop on small change |
| conv_thresh | input | DW | Largest change that counts as converged |
| rd_row | input | AW | Full-grid row to read |
| rd_col | input | AW | Full-grid column to read |
| rd_data | output | DW | Combinational value of the addressed cell |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench compares every cell, including the edge ring, against a model that applies the even class first and then the odd class. A design that updated both classes from the same old values, or updated them in the other order, would give different interior numbers after the first sweep. Grids full of 0xFFFF, and a full 0xFFFF edge around a zero interior, expose a sum that is too narrow: the averages would wrap to small values. Run length is measured from the start pulse to `done`. This catches an off-by-one sweep count, a zero count that hangs or runs 256 sweeps, a threshold compared with strict less-than instead of at-or-below, and a convergence flag that fires even when it is disabled. Writes and a second start issued mid-run check that the run neither absorbs stray data nor restarts.

// File: rtl/rb_relax_pkg.sv
package rb_relax_pkg;
   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } rb_phase_e;

   function automatic int unsigned rb_addr_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rb_cell_avg.sv
module rb_cell_avg #(
   parameter int unsigned DW = 16
) (
   input  logic [DW-1:0] nb_n,
   input  logic [DW-1:0] nb_s,
   input  logic [DW-1:0] nb_e,
   input  logic [DW-1:0] nb_w,
   input  logic [DW-1:0] cur,
   output logic [DW-1:0] avg,
   output logic [DW-1:0] delta
);
   localparam int unsigned SW = DW + 2;

   logic [SW-1:0] pair_ns, pair_ew, total;
   logic [DW-1:0] lo_v, hi_v;

   always_comb begin
      pair_ns = {2'b00, nb_n} + {2'b00, nb_s};
      pair_ew = {2'b00, nb_e} + {2'b00, nb_w};
      total   = pair_ns + pair_ew;
      avg     = total[SW-1:2];
      delta   = (avg >= cur) ? (avg - cur) : (cur - avg);
   end

   // bounds of the neighbours, for the range check below
   always_comb begin
      lo_v = nb_n;
      hi_v = nb_n;
      if (nb_s < lo_v) lo_v = nb_s;
      if (nb_e < lo_v) lo_v = nb_e;
      if (nb_w < lo_v) lo_v = nb_w;
      if (nb_s > hi_v) hi_v = nb_s;
      if (nb_e > hi_v) hi_v = nb_e;
      if (nb_w > hi_v) hi_v = nb_w;
   end

   // R5: a truncated mean never leaves the range of its inputs (a wrap would)
   always_comb begin
      assert_avg_in_range_R5 : assert (avg >= lo_v && avg <= hi_v);
   end
endmodule

// File: rtl/rb_grid_array.sv
module rb_grid_array
   import rb_relax_pkg::*;
#(
   parameter int unsigned NI = 8,
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_accept,
   input  logic [AW-1:0] wr_row,
   input  logic [AW-1:0] wr_col,
   input  logic [DW-1:0] wr_data,
   input  logic          upd_en,
   input  rb_phase_e     upd_phase,
   input  logic [AW-1:0] rd_row,
   input  logic [AW-1:0] rd_col,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] phase_peak
);
   localparam int unsigned G = NI + 2;
   localparam logic [AW:0] G_L = (AW + 1)'(G);

   if ((1 << AW) < G) begin : g_bad_aw
      $error("rb_grid_array: AW too small for grid");
   end

   logic [DW-1:0] grid_q  [G][G];
   logic [DW-1:0] avg_w   [NI][NI];
   logic [DW-1:0] delta_w [NI][NI];

   for (genvar i = 0; i < NI; i++) begin : g_row
      for (genvar j = 0; j < NI; j++) begin : g_col
         rb_cell_avg #(.DW(DW)) u_avg (
            .nb_n (grid_q[i][j+1]),
            .nb_s (grid_q[i+2][j+1]),
            .nb_e (grid_q[i+1][j+2]),
            .nb_w (grid_q[i+1][j]),
            .cur  (grid_q[i+1][j+1]),
            .avg  (avg_w[i][j]),
            .delta(delta_w[i][j])
         );

         localparam rb_phase_e MY_PH = (((i + j) % 2) == 0) ? PH_EVEN : PH_ODD;

         // R3, R4: the class not being updated keeps its value
         assert_class_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && upd_phase != MY_PH) |=> $stable(grid_q[i+1][j+1]));
      end
   end

   // largest change among the cells of the active class
   always_comb begin
      phase_peak = '0;
      for (int i = 0; i < NI; i++) begin
         for (int j = 0; j < NI; j++) begin
            if (((i + j) % 2) == int'(upd_phase) && delta_w[i][j] > phase_peak)
               phase_peak = delta_w[i][j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++)
               grid_q[r][c] <= '0;
      end else if (wr_accept) begin
         if ({1'b0, wr_row} < G_L && {1'b0, wr_col} < G_L)
            grid_q[wr_row][wr_col] <= wr_data;
      end else if (upd_en) begin
         for (int r = 1; r <= NI; r++)
            for (int c = 1; c <= NI; c++)
               if (((r + c) % 2) == int'(upd_phase))
                  grid_q[r][c] <= avg_w[r-1][c-1];
      end
   end

   always_comb begin
      rd_data = '0;
      if ({1'b0, rd_row} < G_L && {1'b0, rd_col} < G_L)
         rd_data = grid_q[rd_row][rd_col];
   end

   for (genvar r = 0; r < G; r++) begin : g_edge_r
      for (genvar c = 0; c < G; c++) begin : g_edge_c
         if (r == 0 || c == 0 || r == G - 1 || c == G - 1) begin : g_edge
            // R6: edge cells move only through the load port
            assert_edge_fixed_R6 : assert property (@(posedge clk) disable iff (!rst_n)
               !wr_accept |=> $stable(grid_q[r][c]));
         end
      end
   end
endmodule

// File: rtl/rb_seq_ctrl.sv
module rb_seq_ctrl
   import rb_relax_pkg::*;
#(
   parameter int unsigned CW = 8,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] iter_count,
   input  logic          conv_en,
   input  logic [DW-1:0] conv_thresh,
   input  logic [DW-1:0] phase_peak,
   output logic          busy,
   output logic          upd_en,
   output rb_phase_e     upd_phase,
   output logic          done
);
   if (CW < 1) begin : g_bad_cw
      $error("rb_seq_ctrl: CW must be at least 1");
   end

   logic          busy_q, done_q, conv_q;
   rb_phase_e     phase_q;
   logic [CW-1:0] remain_q;
   logic [DW-1:0] thr_q, peak0_q, sweep_peak;
   logic          last_iter, conv_hit;

   always_comb begin
      sweep_peak = (phase_peak > peak0_q) ? phase_peak : peak0_q;
      last_iter  = (remain_q == CW'(1));
      conv_hit   = conv_q && (sweep_peak <= thr_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         conv_q   <= 1'b0;
         phase_q  <= PH_EVEN;
         remain_q <= '0;
         thr_q    <= '0;
         peak0_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               if (iter_count == '0) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q   <= 1'b1;
                  phase_q  <= PH_EVEN;
                  remain_q <= iter_count;
                  conv_q   <= conv_en;
                  thr_q    <= conv_thresh;
               end
            end
         end else if (phase_q == PH_EVEN) begin
            peak0_q <= phase_peak;
            phase_q <= PH_ODD;
         end else begin
            phase_q <= PH_EVEN;
            if (last_iter || conv_hit) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               remain_q <= remain_q - CW'(1);
            end
         end
      end
   end

   assign busy      = busy_q;
   assign upd_en    = busy_q;
   assign upd_phase = phase_q;
   assign done      = done_q;

   assert_done_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (!done_q || $past(start)));
   assert_busy_ends_with_done_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   assert_count_live_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (remain_q != '0));
   assert_idle_phase_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (phase_q == PH_EVEN));
   // R9: a run never ends or restarts in its first half-step
   assert_no_restart_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && phase_q == PH_EVEN) |=> (busy_q && phase_q == PH_ODD));
endmodule

// File: rtl/rb_relax_top.sv
module rb_relax_top
   import rb_relax_pkg::*;
#(
   parameter int unsigned NI = 8,
   parameter int unsigned DW = 16,
   parameter int unsigned CW = 8,
   localparam int unsigned AW = rb_addr_bits(NI + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_row,
   input  logic [AW-1:0] wr_col,
   input  logic [DW-1:0] wr_data,
   input  logic          start,
   input  logic [CW-1:0] iter_count,
   input  logic          conv_en,
   input  logic [DW-1:0] conv_thresh,
   input  logic [AW-1:0] rd_row,
   input  logic [AW-1:0] rd_col,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          done
);
   if (NI < 2) begin : g_bad_ni
      $error("rb_relax_top: interior must be at least 2x2");
   end
   if ((NI + 2) * (NI + 2) > 1024) begin : g_bad_size
      $error("rb_relax_top: grid too large for register storage");
   end
   if (DW < 2) begin : g_bad_dw
      $error("rb_relax_top: DW must be at least 2");
   end

   logic          upd_en, wr_accept;
   rb_phase_e     upd_phase;
   logic [DW-1:0] phase_peak;

   assign wr_accept = wr_en && !busy;

   rb_seq_ctrl #(.CW(CW), .DW(DW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .iter_count (iter_count),
      .conv_en    (conv_en),
      .conv_thresh(conv_thresh),
      .phase_peak (phase_peak),
      .busy       (busy),
      .upd_en     (upd_en),
      .upd_phase  (upd_phase),
      .done       (done)
   );

   rb_grid_array #(.NI(NI), .DW(DW), .AW(AW)) u_grid (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_accept (wr_accept),
      .wr_row    (wr_row),
      .wr_col    (wr_col),
      .wr_data   (wr_data),
      .upd_en    (upd_en),
      .upd_phase (upd_phase),
      .rd_row    (rd_row),
      .rd_col    (rd_col),
      .rd_data   (rd_data),
      .phase_peak(phase_peak)
   );

   // R9: a write while busy never reaches the grid
   assert_write_gated_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |-> !wr_accept);
endmodule

// File: tb/rb_relax_top_tb.sv
`timescale 1ns/1ps
module rb_relax_top_tb;
   localparam int NI = 8;
   localparam int G  = NI + 2;
   localparam int DW = 16;
   localparam int CW = 8;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
   logic [DW-1:0] wr_data = '0, conv_thresh = '0;
   logic          start = 1'b0, conv_en = 1'b0;
   logic [CW-1:0] iter_count = '0;
   logic [DW-1:0] rd_data;
   logic          busy, done;

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   int mdl [G][G];

   always #2.5 clk = ~clk;

   rb_relax_top #(.NI(NI), .DW(DW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_data(wr_data), .start(start), .iter_count(iter_count), .conv_en(conv_en),
      .conv_thresh(conv_thresh), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
      .busy(busy), .done(done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic rd(input int r, input int c, output int v);
      rd_row = AW'(r);
      rd_col = AW'(c);
      #1;
      v = int'(rd_data);
   endtask

   task automatic wr_cell(input int r, input int c, input int v);
      @(negedge clk);
      wr_en = 1'b1; wr_row = AW'(r); wr_col = AW'(c); wr_data = DW'(v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // mode 0: gradients, 1: all max, 2: uniform, 3: max edge / zero interior
   task automatic load_grid(input int mode);
      for (int r = 0; r < G; r++) begin
         for (int c = 0; c < G; c++) begin
            bit edge_c = (r == 0 || c == 0 || r == G - 1 || c == G - 1);
            int v;
            case (mode)
               0: v = edge_c ? ((r * 6007 + c * 2311) & 16'hFFFF)
                             : ((r * 37 + c * 91) * 13 & 16'hFFFF);
               1: v = 16'hFFFF;
               2: v = 1234;
               default: v = edge_c ? 16'hFFFF : 0;
            endcase
            mdl[r][c] = v;
            wr_cell(r, c, v);
         end
      end
   endtask

   task automatic cmp_grid(input string req_in);
      for (int r = 0; r < G; r++) begin
         for (int c = 0; c < G; c++) begin
            int v;
            bit edge_c = (r == 0 || c == 0 || r == G - 1 || c == G - 1);
            rd(r, c, v);
            chk(edge_c ? "R6" : req_in, $sformatf("cell(%0d,%0d)", r, c), v, mdl[r][c]);
         end
      end
   endtask

   // even class first, then odd; returns sweeps executed
   function automatic int model_run(input int k, input bit cv, input int thr);
      for (int it = 1; it <= k; it++) begin
         int md = 0;
         for (int ph = 0; ph < 2; ph++)
            for (int r = 1; r <= NI; r++)
               for (int c = 1; c <= NI; c++)
                  if (((r + c) % 2) == ph) begin
                     int a = (mdl[r-1][c] + mdl[r+1][c] + mdl[r][c-1] + mdl[r][c+1]) >> 2;
                     int d = (a > mdl[r][c]) ? a - mdl[r][c] : mdl[r][c] - a;
                     if (d > md) md = d;
                     mdl[r][c] = a;
                  end
         if (cv && md <= thr) return it;
      end
      return k;
   endfunction

   task automatic run(input int k, input bit cv, input int thr, input bit poke, input string req);
      int exp_it, cnt;
      exp_it = model_run(k, cv, thr);
      @(negedge clk);
      start = 1'b1; iter_count = CW'(k); conv_en = cv; conv_thresh = DW'(thr);
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      chk(k == 0 ? "R8" : "R7", "busy after start", int'(busy), k == 0 ? 0 : 1);
      while (!done && cnt < 1000) begin
         @(negedge clk);
         cnt++;
         if (poke && cnt == 1) begin
            wr_en = 1'b1; wr_row = 4'd3; wr_col = 4'd3; wr_data = 16'hABCD;
            start = 1'b1; iter_count = 8'd50;
         end else if (poke && cnt == 2) begin
            wr_row = 4'd0; wr_col = 4'd4; wr_data = 16'd7; start = 1'b0;
         end else begin
            wr_en = 1'b0; start = 1'b0;
         end
      end
      chk(req, "cycles to done", cnt, 2 * exp_it);
      @(negedge clk);
      chk("R7", "done one cycle", int'(done), 0);
      chk("R7", "busy low after run", int'(busy), 0);
   endtask

   task automatic t_reset;
      int v;
      chk("R1", "done at reset", int'(done), 0);
      chk("R1", "busy at reset", int'(busy), 0);
      cmp_grid("R1");
      rd(12, 1, v);
      chk("R2", "out-of-grid read", v, 0);
   endtask

   task automatic t_load;        load_grid(0); cmp_grid("R2"); endtask
   task automatic t_one_sweep;   run(1, 0, 0, 0, "R7"); cmp_grid("R3"); endtask
   task automatic t_many_sweeps; run(5, 0, 0, 0, "R7"); cmp_grid("R4"); endtask
   task automatic t_saturate;
      load_grid(1); run(2, 0, 0, 0, "R7"); cmp_grid("R5");
      load_grid(3); run(3, 0, 0, 0, "R7"); cmp_grid("R5");
   endtask
   task automatic t_zero_count;  load_grid(0); run(0, 0, 0, 0, "R8"); cmp_grid("R8"); endtask
   task automatic t_busy_ignore; run(3, 0, 0, 1, "R9"); cmp_grid("R9"); endtask
   task automatic t_conv_loose;  load_grid(0); run(20, 1, 16'hFFFF, 0, "R10"); cmp_grid("R10"); endtask
   task automatic t_conv_exact;  load_grid(2); run(6, 1, 0, 0, "R10"); cmp_grid("R10"); endtask
   task automatic t_conv_mid;    load_grid(0); run(40, 1, 50, 0, "R10"); cmp_grid("R10"); endtask
   task automatic t_conv_off;    load_grid(2); run(4, 0, 0, 0, "R11"); cmp_grid("R11"); endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < G; r++) for (int c = 0; c < G; c++) mdl[r][c] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_one_sweep();
      t_many_sweeps();
      t_saturate();
      t_zero_count();
      t_busy_ignore();
      t_conv_loose();
      t_conv_exact();
      t_conv_mid();
      t_conv_off();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule